// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block converts a binary DAC code into the switch controls of a segmented voltage DAC. The analog core is a string of equal resistors whose nodes are numbered from the bottom tap upward. Two tap selectors pick the two ends of one string segment. A sub-DAC then interpolates between the two selected voltages. The upper code bits name the segment and the lower bits form the interpolation code.

The selectors leapfrog along the string. Selector A only ever lands on even-indexed taps and selector B only on odd-indexed taps. When the code crosses into the next segment, one selector keeps the tap the two segments share and the other jumps two taps ahead. On every other segment selector A sits above selector B, so the inputs of the sub-DAC are swapped. The block then raises a polarity flag and complements the interpolation code so that the analog level still rises with the code.

A load strobe captures the input code. One clock later the block presents the new one-hot selector words, the polarity flag and the sub-DAC code, all from registers, together with a one-cycle valid pulse.

Top module: `seg_dac_switch_decoder`

## Requirements
- R1: After reset, `tap_even_o` is 9'b000000001 (tap 0), `tap_odd_o` is 8'b00000001 (tap 1), `swap_o` is 0, `interp_o` is 0 and `valid_o` is 0. This is the result for code 0.
- R2: `valid_o` is high in the cycle after a cycle with `load_i` high, and low in every other cycle. A load updates every result output in that same next cycle.
- R3: While `load_i` is low, all result outputs hold their values, whatever `code_i` does.
- R4: Bit i of `tap_even_o` drives tap 2i. Exactly one bit is set. For segment k = `code_i[15:12]`, the set bit is bit (k+1)/2, rounded down.
- R5: Bit j of `tap_odd_o` drives tap 2j+1. Exactly one bit is set. For segment k, the set bit is bit k/2, rounded down.
- R6: The two selected taps differ by exactly one, and the lower of the two is tap k.
- R7: `swap_o` is 1 exactly when k is odd, meaning selector A holds the upper tap.
- R8: `interp_o` equals `code_i[11:0]` for even k and its bitwise complement for odd k.
- R9: The ideal level is 4096 times the lower tap index, plus `interp_o`, with `interp_o` complemented when `swap_o` is 1. This level equals the loaded code for every code, so it rises strictly across a full ascending sweep.
- R10: When the loaded code moves from segment k to segment k+1, exactly one selector word changes. The selector that does not change sits on tap k+1, the tap the two segments share.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Captures `code_i` this cycle |
| code_i | input | 16 | DAC code: bits 15:12 are the segment, bits 11:0 the interpolation |
| tap_even_o | output | 9 | One-hot selector A, bit i = tap 2i |
| tap_odd_o | output | 8 | One-hot selector B, bit j = tap 2j+1 |
| swap_o | output | 1 | Selector A is the upper input of the sub-DAC |
| interp_o | output | 12 | Sub-DAC code after polarity correction |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Two events can land in the same cycle. A new load can arrive while the valid pulse of the previous load is still high. A segment crossing, which moves one selector, also flips the polarity and complements the sub-DAC code. The bench provokes both with a back-to-back load of all 65,536 codes in ascending order. Each cycle it rebuilds the ideal level from the output switches and checks that the level equals the code and exceeds the previous one, with exactly one selector moving at each boundary. Gapped and random load patterns, with `code_i` moving while `load_i` is low, show that a held result is not disturbed.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
   // Order of the two selected taps as seen by the sub-DAC inputs.
   typedef enum logic {
      POL_DIRECT  = 1'b0,   // even-tap selector is the lower input
      POL_SWAPPED = 1'b1    // even-tap selector is the upper input
   } pol_e;

   // Index of the even tap that bounds segment seg.
   function automatic int unsigned even_slot(int unsigned seg);
      return (seg + 1) / 2;
   endfunction

   // Index of the odd tap that bounds segment seg.
   function automatic int unsigned odd_slot(int unsigned seg);
      return seg / 2;
   endfunction
endpackage

// File: rtl/seg_tap_steer.sv
module seg_tap_steer #(
   parameter int SEG_BITS = 4,
   localparam int NSEG    = 1 << SEG_BITS,
   localparam int A_W     = NSEG / 2 + 1,
   localparam int B_W     = NSEG / 2
) (
   input  logic [SEG_BITS-1:0] seg_i,
   output logic [A_W-1:0]      even_sel_o,
   output logic [B_W-1:0]      odd_sel_o,
   output seg_dac_pkg::pol_e   pol_o
);
   logic [31:0] seg_w;
   assign seg_w = 32'(seg_i);

   // Even tap 2i bounds segment 2i from below and segment 2i-1 from above.
   for (genvar i = 0; i < A_W; i++) begin : g_even
      if (i == 0) begin : g_floor
         assign even_sel_o[i] = (seg_w == 32'd0);
      end else if (2 * i > NSEG - 1) begin : g_ceiling
         assign even_sel_o[i] = (seg_w == 32'(2 * i - 1));
      end else begin : g_mid
         assign even_sel_o[i] = (seg_w == 32'(2 * i)) || (seg_w == 32'(2 * i - 1));
      end
   end

   // Odd tap 2j+1 bounds segments 2j and 2j+1.
   for (genvar j = 0; j < B_W; j++) begin : g_odd
      assign odd_sel_o[j] = (seg_w[31:1] == 31'(j));
   end

   assign pol_o = seg_i[0] ? seg_dac_pkg::POL_SWAPPED : seg_dac_pkg::POL_DIRECT;

   // R4 / R5: each selector closes exactly one switch.
   always_comb begin
      a_r4_even_single : assert ($countones(even_sel_o) == 1)
         else $error("even selector not one-hot");
      a_r5_odd_single : assert ($countones(odd_sel_o) == 1)
         else $error("odd selector not one-hot");
   end
endmodule

// File: rtl/seg_interp_code.sv
module seg_interp_code #(
   parameter int SUB_W = 12
) (
   input  logic [SUB_W-1:0] frac_i,
   input  seg_dac_pkg::pol_e pol_i,
   output logic [SUB_W-1:0] code_o
);
   for (genvar b = 0; b < SUB_W; b++) begin : g_bit
      assign code_o[b] = frac_i[b] ^ (pol_i == seg_dac_pkg::POL_SWAPPED);
   end
endmodule

// File: rtl/seg_dac_switch_decoder.sv
module seg_dac_switch_decoder #(
   parameter int CODE_W   = 16,
   parameter int SEG_BITS = 4,
   localparam int SUB_W   = CODE_W - SEG_BITS,
   localparam int NSEG    = 1 << SEG_BITS,
   localparam int A_W     = NSEG / 2 + 1,
   localparam int B_W     = NSEG / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [A_W-1:0]    tap_even_o,
   output logic [B_W-1:0]    tap_odd_o,
   output logic              swap_o,
   output logic [SUB_W-1:0]  interp_o,
   output logic              valid_o
);
   import seg_dac_pkg::*;

   if (SEG_BITS < 1 || SEG_BITS > 8) begin : g_bad_seg
      $error("SEG_BITS out of range");
   end
   if (SUB_W < 1) begin : g_bad_sub
      $error("CODE_W must exceed SEG_BITS");
   end

   logic [A_W-1:0]   even_d;
   logic [B_W-1:0]   odd_d;
   pol_e             pol_d;
   logic [SUB_W-1:0] interp_d;

   seg_tap_steer #(.SEG_BITS(SEG_BITS)) u_steer (
      .seg_i      (code_i[CODE_W-1:SUB_W]),
      .even_sel_o (even_d),
      .odd_sel_o  (odd_d),
      .pol_o      (pol_d)
   );

   seg_interp_code #(.SUB_W(SUB_W)) u_interp (
      .frac_i (code_i[SUB_W-1:0]),
      .pol_i  (pol_d),
      .code_o (interp_d)
   );

   pol_e pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_even_o <= A_W'(1);
         tap_odd_o  <= B_W'(1);
         pol_q      <= POL_DIRECT;
         interp_o   <= '0;
         valid_o    <= 1'b0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            tap_even_o <= even_d;
            tap_odd_o  <= odd_d;
            pol_q      <= pol_d;
            interp_o   <= interp_d;
         end
      end
   end

   assign swap_o = (pol_q == POL_SWAPPED);

   // R2: the valid pulse follows each load and nothing else.
   a_r2_valid_after_load : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> valid_o);
   a_r2_no_spurious_valid : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !valid_o);
   // R3: a result is held while no load arrives.
   a_r3_hold_result : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(tap_even_o) && $stable(tap_odd_o) &&
                   $stable(swap_o) && $stable(interp_o)));
   // R7: the flag follows the parity of the captured segment.
   a_r7_swap_parity : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (swap_o == $past(code_i[SUB_W])));
   // R8: the sub-DAC code is the captured fraction, flipped under swap.
   a_r8_interp_polarity : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (interp_o == ($past(code_i[SUB_W-1:0]) ^ {SUB_W{swap_o}})));
endmodule

// File: tb/seg_dac_switch_decoder_tb.sv
`timescale 1ns/1ps
module seg_dac_switch_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] code_i = '0;
   logic [8:0]  tap_even_o;
   logic [7:0]  tap_odd_o;
   logic        swap_o;
   logic [11:0] interp_o;
   logic        valid_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   seg_dac_switch_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .code_i(code_i),
      .tap_even_o(tap_even_o), .tap_odd_o(tap_odd_o), .swap_o(swap_o),
      .interp_o(interp_o), .valid_o(valid_o)
   );

   // Behavioural reference: last captured code and valid expectation.
   int exp_code  = 0;
   bit exp_valid = 1'b0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_code  <= 0;
         exp_valid <= 1'b0;
      end else begin
         exp_valid <= load_i;
         if (load_i) exp_code <= int'(code_i);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d code=%0d t=%0t", req, act, exp, exp_code, $time);
      end
   endtask

   // Compare on every falling edge.
   bit sweep_on = 1'b0;
   int prev_level = -1;
   int prev_seg = -1;
   logic [8:0] prev_a;
   logic [7:0] prev_b;

   always @(negedge clk) begin
      if (rst_n) begin
         int k, ai, bi, ta, tb, lo, eff, lvl, dif;
         k = exp_code >> 12;
         check("R2 valid", int'(valid_o), int'(exp_valid));
         check("R4 even selector", int'(tap_even_o), 1 << ((k + 1) / 2));
         check("R5 odd selector", int'(tap_odd_o), 1 << (k / 2));
         check("R7 swap flag", int'(swap_o), k % 2);
         check("R8 interp code", int'(interp_o),
               (k % 2 == 1) ? 4095 - (exp_code & 4095) : (exp_code & 4095));
         ai = -1; bi = -1;
         for (int i = 0; i < 9; i++) if (tap_even_o[i]) ai = i;
         for (int j = 0; j < 8; j++) if (tap_odd_o[j]) bi = j;
         ta = 2 * ai; tb = 2 * bi + 1;
         lo = (ta < tb) ? ta : tb;
         dif = (ta > tb) ? ta - tb : tb - ta;
         check("R6 adjacent taps", dif, 1);
         check("R6 lower tap", lo, k);
         eff = swap_o ? 4095 - int'(interp_o) : int'(interp_o);
         lvl = 4096 * lo + eff;
         check("R9 level", lvl, exp_code);
         if (sweep_on && valid_o) begin
            if (prev_level >= 0) check("R9 strictly rising", int'(lvl > prev_level), 1);
            if (prev_seg >= 0 && k == prev_seg + 1) begin
               check("R10 one selector moves",
                     int'(tap_even_o != prev_a) + int'(tap_odd_o != prev_b), 1);
               if (tap_even_o == prev_a) check("R10 kept tap", ta, k);
               else                      check("R10 kept tap", tb, k);
            end
            prev_level = lvl; prev_seg = k;
            prev_a = tap_even_o; prev_b = tap_odd_o;
         end
      end
   end

   task automatic load_code(input int c);
      @(negedge clk);
      code_i = 16'(c);
      load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic idle_wiggle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         code_i = 16'($urandom);
         load_i = 1'b0;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset values, checked while reset is still asserted.
      check("R1 even reset", int'(tap_even_o), 1);
      check("R1 odd reset", int'(tap_odd_o), 1);
      check("R1 swap reset", int'(swap_o), 0);
      check("R1 interp reset", int'(interp_o), 0);
      check("R1 valid reset", int'(valid_o), 0);
      rst_n = 1'b1;
      // Directed codes with gaps; code_i moves while idle (R3).
      load_code(16'h0000); idle_wiggle(3);
      load_code(16'h1ABC); idle_wiggle(3);
      load_code(16'hFFFF); idle_wiggle(2);
      load_code(16'h8000); idle_wiggle(2);
      load_code(16'h7FFF); idle_wiggle(2);
      load_code(16'h0FFF); load_code(16'h1000); idle_wiggle(2);
      // Full ascending sweep, back-to-back loads (R9, R10).
      @(negedge clk);
      sweep_on = 1'b1;
      for (int c = 0; c < 65536; c++) begin
         code_i = 16'(c);
         load_i = 1'b1;
         @(negedge clk);
      end
      load_i = 1'b0;
      @(negedge clk);
      sweep_on = 1'b0;
      // Random load pattern.
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         code_i = 16'($urandom);
         load_i = ($urandom % 3) == 0;
      end
      @(negedge clk); load_i = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule